// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This controller sits between a processor's load/store port and the memory side of a system. Loads to cacheable addresses are looked up in a direct-mapped array. The number of lines and the number of words per line are parameters, and both must be powers of two and at least 2. A load hit is answered in the same cycle. A load miss makes the controller fetch the whole line as a burst and fill it. The controller then answers with the requested word.

Every store is sent at once to an external write buffer. The array is changed only when the stored word's line is already present, and a store miss never allocates a line. Addresses that satisfy `(addr & UNC_MASK) == UNC_BASE` are uncached. These bypass the array in both directions: a load reads a single word from memory and a store only enters the write buffer. An external command can drop any one line, given by its index. All addresses are word addresses. The index is taken from the bits just above the word offset, and the tag from the bits above the index.

The processor holds `cpu_req` together with its address, direction and data until `cpu_ack` is seen high at a clock edge.

Top module: `wt_dcache`

## Requirements
- R1: While reset is held, `cpu_ack`, `mem_rd_req` and `wb_valid` are low. After reset no line is valid, so the first cached load to any address misses.
- R2: A cached load whose line is valid with a matching tag raises `cpu_ack` in the cycle it is presented, with the stored word on `cpu_rdata`, and issues no memory read.
- R3: A cached load miss raises `mem_rd_req` with `mem_rd_single`=0 and the line-aligned address (offset bits zero). It takes WORDS beats on `mem_rd_valid` in ascending offset order. It acks in the cycle after the last beat with the word at the requested offset, and the line then hits.
- R4: Every store drives `wb_valid` with `wb_addr`/`wb_data` equal to the request. It is acknowledged in the same cycle that `wb_ready` is high.
- R5: A store that hits replaces that word in the array. A store that misses changes no line and issues no memory read.
- R6: A load to an uncached address issues a read with `mem_rd_single`=1 at the exact address, takes one beat and never fills the array. An uncached store only enters the write buffer.
- R7: A pulse on `inv_valid` clears the valid state of line `inv_index`, and the next load to that line misses.
- R8: An invalidate of the line being refilled, arriving while the read request or any of its beats is pending, lets the refill finish and return the right word, but leaves the line invalid.
- R9: While a store is presented and `wb_ready` is low, `cpu_ack` stays low.
- R10: `mem_rd_req` and `mem_rd_addr` stay steady until `mem_rd_gnt` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DW | Load data, valid with `cpu_ack` |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_single | output | 1 | 1 = single word, 0 = full line burst |
| mem_rd_addr | output | AW | Read address |
| mem_rd_gnt | input | 1 | Read request accepted |
| mem_rd_valid | input | 1 | Read data beat valid |
| mem_rd_data | input | DW | Read data beat |
| wb_valid | output | 1 | Store offered to the write buffer |
| wb_addr | output | AW | Store address |
| wb_data | output | DW | Store data |
| wb_ready | input | 1 | Write buffer can accept |
| inv_valid | input | 1 | Invalidate one line |
| inv_index | input | log2(LINES) | Line to invalidate |

## Verification
A valid bit left set by mistake, whether after an invalidate or after a refill that raced one, shows up on the next load to that line. That load is acknowledged at once with no read request, where a miss was due, so the error is visible one access later. A word not updated by a store hit, or a refill beat written at the wrong offset, shows up as a wrong `cpu_rdata` on the next hit to that word. Stimulus mixes directed races with random traffic over a small address space, so hits, conflict misses, uncached accesses and invalidates interleave. Every load is checked both for the value returned and for whether a read was issued.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDREQ = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } dc_state_e;
endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int LINES = 16,
    parameter int TAGW  = 26,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_valid,
    output logic [TAGW-1:0] rd_tag,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic [TAGW-1:0] set_tag,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx
);
    logic [LINES-1:0]      valid_vec;
    logic [LINES*TAGW-1:0] tag_flat;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic            v_q;
        logic [TAGW-1:0] t_q;

        // clear wins over set when both name the same line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (clr_en && clr_idx == IDXW'(g)) begin
                v_q <= 1'b0;
            end else if (set_en && set_idx == IDXW'(g)) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (set_en && set_idx == IDXW'(g)) begin
                t_q <= set_tag;
            end
        end

        assign valid_vec[g]            = v_q;
        assign tag_flat[g*TAGW +: TAGW] = t_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_tag   = tag_flat[rd_idx*TAGW +: TAGW];
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IDXW = $clog2(LINES),
    localparam int OFFW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [OFFW-1:0] rd_off,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [OFFW-1:0] wr_off,
    input  logic [DW-1:0]   wr_data
);
    logic [DW-1:0] store_q [LINES*WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    assign rd_data = store_q[{rd_idx, rd_off}];
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LINES = 16,
    parameter int WORDS = 4,
    parameter logic [AW-1:0] UNC_BASE = 32'hF000_0000,
    parameter logic [AW-1:0] UNC_MASK = 32'hF000_0000,
    localparam int IDXW = $clog2(LINES),
    localparam int OFFW = $clog2(WORDS),
    localparam int TAGW = AW - IDXW - OFFW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_ack,
    output logic [DW-1:0]   cpu_rdata,
    output logic            mem_rd_req,
    output logic            mem_rd_single,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_gnt,
    input  logic            mem_rd_valid,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic [DW-1:0]   wb_data,
    input  logic            wb_ready,
    input  logic            inv_valid,
    input  logic [IDXW-1:0] inv_index
);
    typedef struct packed {
        dc_state_e       st;
        logic [OFFW-1:0] cnt;      // next refill beat offset
        logic            inv_seen; // target line invalidated during refill
        logic            unc;      // current miss is an uncached access
        logic [DW-1:0]   word;     // word held for the response cycle
    } ctl_t;

    ctl_t c_q, c_d;

    logic [TAGW-1:0] a_tag;
    logic [IDXW-1:0] a_idx;
    logic [OFFW-1:0] a_off;
    logic            is_unc, hit, inv_same;
    logic            tv_valid;
    logic [TAGW-1:0] tv_tag;
    logic [DW-1:0]   arr_word;
    logic            set_en, dwe;
    logic [OFFW-1:0] dw_off;
    logic [DW-1:0]   dw_data;

    assign a_tag    = cpu_addr[AW-1 -: TAGW];
    assign a_idx    = cpu_addr[OFFW +: IDXW];
    assign a_off    = cpu_addr[OFFW-1:0];
    assign is_unc   = (cpu_addr & UNC_MASK) == UNC_BASE;
    assign hit      = tv_valid && (tv_tag == a_tag) && !is_unc;
    assign inv_same = inv_valid && (inv_index == a_idx);

    dc_tag_array #(.LINES(LINES), .TAGW(TAGW)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_valid (tv_valid),
        .rd_tag   (tv_tag),
        .set_en   (set_en),
        .set_idx  (a_idx),
        .set_tag  (a_tag),
        .clr_en   (inv_valid),
        .clr_idx  (inv_index)
    );

    dc_data_array #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_off  (a_off),
        .rd_data (arr_word),
        .wr_en   (dwe),
        .wr_idx  (a_idx),
        .wr_off  (dw_off),
        .wr_data (dw_data)
    );

    always_comb begin
        c_d        = c_q;
        cpu_ack    = 1'b0;
        mem_rd_req = 1'b0;
        wb_valid   = 1'b0;
        set_en     = 1'b0;
        dwe        = 1'b0;
        dw_off     = a_off;
        dw_data    = cpu_wdata;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        wb_valid = 1'b1;
                        if (wb_ready) begin
                            cpu_ack = 1'b1;
                            dwe     = hit;
                        end
                    end else if (hit) begin
                        cpu_ack = 1'b1;
                    end else begin
                        c_d.st       = ST_RDREQ;
                        c_d.unc      = is_unc;
                        c_d.inv_seen = 1'b0;
                        c_d.cnt      = '0;
                    end
                end
            end
            ST_RDREQ: begin
                mem_rd_req = 1'b1;
                if (inv_same) c_d.inv_seen = 1'b1;
                if (mem_rd_gnt) c_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (inv_same) c_d.inv_seen = 1'b1;
                if (mem_rd_valid) begin
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (!c_q.unc) begin
                        dwe     = 1'b1;
                        dw_off  = c_q.cnt;
                        dw_data = mem_rd_data;
                    end
                    if (c_q.unc || c_q.cnt == a_off) c_d.word = mem_rd_data;
                    if (c_q.unc || c_q.cnt == OFFW'(WORDS-1)) begin
                        c_d.st = ST_RESP;
                        set_en = !c_q.unc && !c_q.inv_seen && !inv_same;
                    end
                end
            end
            ST_RESP: begin
                cpu_ack = 1'b1;
                c_d.st  = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_rdata     = (c_q.st == ST_RESP) ? c_q.word : arr_word;
    assign mem_rd_single = c_q.unc;
    assign mem_rd_addr   = c_q.unc ? cpu_addr : {cpu_addr[AW-1:OFFW], {OFFW{1'b0}}};
    assign wb_addr       = cpu_addr;
    assign wb_data       = cpu_wdata;
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
    parameter int AW    = 32,
    parameter int WORDS = 4,
    parameter logic [AW-1:0] UNC_BASE = 32'hF000_0000,
    parameter logic [AW-1:0] UNC_MASK = 32'hF000_0000,
    localparam int OFFW = $clog2(WORDS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_ack,
    input logic          mem_rd_req,
    input logic          mem_rd_single,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_gnt,
    input logic          wb_valid,
    input logic          wb_ready
);
    AST_STORE_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_ack |-> wb_valid && wb_ready); // R4
    AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |-> !cpu_ack); // R9
    AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we |-> !mem_rd_req); // R5
    AST_UNCACHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && ((mem_rd_addr & UNC_MASK) == UNC_BASE) |-> mem_rd_single); // R6
    AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_single |-> mem_rd_addr[OFFW-1:0] == '0); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_gnt |=> mem_rd_req && $stable(mem_rd_addr)); // R10
endmodule

bind wt_dcache dc_checker #(
    .AW(AW), .WORDS(WORDS), .UNC_BASE(UNC_BASE), .UNC_MASK(UNC_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_ack       (cpu_ack),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_single (mem_rd_single),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_gnt    (mem_rd_gnt),
    .wb_valid      (wb_valid),
    .wb_ready      (wb_ready)
);

// File: tb/wt_dcache_tb.sv
`timescale 1ns/1ps
module wt_dcache_tb;
    localparam int AW = 32, DW = 32, LINES = 16, WORDS = 4;
    localparam int IDXW = $clog2(LINES), OFFW = $clog2(WORDS);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cpu_req, cpu_we, cpu_ack, mem_rd_req, mem_rd_single, mem_rd_gnt, mem_rd_valid;
    logic wb_valid, wb_ready, inv_valid;
    logic [AW-1:0] cpu_addr, mem_rd_addr, wb_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata, mem_rd_data, wb_data;
    logic [IDXW-1:0] inv_index;

    wt_dcache u_dut (.*);

    int n_cmp = 0, n_bad = 0;
    logic [DW-1:0] shadow [logic [AW-1:0]];
    bit mvalid [LINES];
    logic [AW-1:0] mtag [LINES];

    function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
        if (shadow.exists(a)) return shadow[a];
        return a * 32'h9E37_79B1 + 32'h1234_5678;
    endfunction
    function automatic bit unc_of(logic [AW-1:0] a);
        return (a & 32'hF000_0000) == 32'hF000_0000;
    endfunction
    function automatic logic [IDXW-1:0] idx_of(logic [AW-1:0] a);
        return a[OFFW +: IDXW];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // load with optional invalidate during refill beat inv_beat and a grant delay
    task automatic do_load(input logic [AW-1:0] a, input int inv_beat,
                           input logic [IDXW-1:0] inv_i, input int gdly);
        bit exp_unc = unc_of(a);
        logic [IDXW-1:0] li = idx_of(a);
        logic [AW-1:0] lt = a >> (OFFW + IDXW);
        bit exp_hit = !exp_unc && mvalid[li] && mtag[li] == lt;
        logic [AW-1:0] base = exp_unc ? a : {a[AW-1:OFFW], {OFFW{1'b0}}};
        int beats = exp_unc ? 1 : WORDS;
        bit saw_req = 0, acked = 0, inv_same = 0;
        int phase = 0, cnt = 0, held = 0;
        logic [DW-1:0] got = '0;
        string rq = exp_unc ? "R6" : (exp_hit ? "R2" : "R3");
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        for (int cyc = 0; cyc < 100; cyc++) begin
            if (cyc > 0) @(negedge clk);
            mem_rd_gnt = 0; mem_rd_valid = 0; inv_valid = 0;
            if (phase == 1 && cnt < beats) begin
                mem_rd_valid = 1;
                mem_rd_data = memval(base + cnt);
                if (cnt == inv_beat) begin
                    inv_valid = 1; inv_index = inv_i; mvalid[inv_i] = 0;
                    if (inv_i == li) inv_same = 1;
                end
                cnt++;
            end
            #1;
            if (cpu_ack) begin got = cpu_rdata; acked = 1; break; end
            if (phase == 0 && mem_rd_req) begin
                if (!saw_req) begin
                    saw_req = 1;
                    chk(mem_rd_addr == base, {rq, " read address"}, mem_rd_addr, base);
                    chk(mem_rd_single == exp_unc, {rq, " single flag"}, mem_rd_single, exp_unc);
                end else begin
                    chk(mem_rd_addr == base, "R10 address stable", mem_rd_addr, base);
                end
                if (held == gdly) begin mem_rd_gnt = 1; phase = 1; end
                else held++;
            end else if (phase == 0 && saw_req) begin
                chk(0, "R10 request dropped before grant", 0, 1);
            end
        end
        chk(acked, {rq, " load acknowledged"}, acked, 1);
        chk(saw_req == !exp_hit, {rq, " read issued iff miss"}, saw_req, !exp_hit);
        chk(got == memval(a), {rq, " load data"}, got, memval(a));
        if (!exp_hit) chk(cnt == beats, {rq, " beats consumed"}, cnt, beats);
        if (!exp_unc && !exp_hit && !inv_same) begin mvalid[li] = 1; mtag[li] = lt; end
        @(negedge clk);
        cpu_req = 0; inv_valid = 0; mem_rd_valid = 0; mem_rd_gnt = 0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input int stall);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; wb_ready = 0;
        for (int i = 0; i < stall; i++) begin
            #1;
            chk(!cpu_ack && wb_valid, "R9 stalled store not acked", {cpu_ack, wb_valid}, 2'b01);
            @(negedge clk);
        end
        wb_ready = 1;
        #1;
        chk(cpu_ack && wb_valid, "R4 store acked with buffer ready", {cpu_ack, wb_valid}, 2'b11);
        chk(wb_addr == a && wb_data == d, "R4 store forwarded", {wb_addr, wb_data}, {a, d});
        chk(!mem_rd_req, "R5 store issues no read", mem_rd_req, 0);
        shadow[a] = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0; wb_ready = 0;
    endtask

    task automatic do_inv(input logic [IDXW-1:0] i);
        @(negedge clk);
        inv_valid = 1; inv_index = i; mvalid[i] = 0;
        @(negedge clk);
        inv_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        mem_rd_gnt = 0; mem_rd_valid = 0; mem_rd_data = '0; wb_ready = 0;
        inv_valid = 0; inv_index = '0;
        for (int i = 0; i < LINES; i++) begin mvalid[i] = 0; mtag[i] = '0; end
        repeat (3) @(negedge clk);
        #1;
        chk(!cpu_ack && !mem_rd_req && !wb_valid, "R1 outputs quiet in reset",
            {cpu_ack, mem_rd_req, wb_valid}, 0);
        @(negedge clk); rst_n = 1;

        // R1/R3: first access misses, then R2 hits on the same line
        do_load(32'h40, -1, '0, 0);
        do_load(32'h43, -1, '0, 0);
        do_load(32'h41, -1, '0, 2);
        // R5: store hit updates, store miss does not allocate
        do_store(32'h42, 32'hDEAD_BEEF, 0);
        do_load(32'h42, -1, '0, 0);
        do_store(32'h204, 32'h0BAD_F00D, 1);
        do_load(32'h204, -1, '0, 0);
        // R6: uncached accesses never fill
        do_load(32'hF000_0010, -1, '0, 1);
        do_load(32'hF000_0010, -1, '0, 0);
        do_store(32'hF000_0011, 32'h1111_2222, 0);
        do_load(32'hF000_0011, -1, '0, 0);
        // R7: invalidate drops a line
        do_load(32'h44, -1, '0, 0);
        do_load(32'h44, -1, '0, 0);
        do_inv(idx_of(32'h44));
        do_load(32'h44, -1, '0, 0);
        // R8: invalidate of the refilling line, middle and last beat
        do_load(32'h89, 1, idx_of(32'h89), 0);
        do_load(32'h89, -1, '0, 0);
        do_load(32'hCB, 3, idx_of(32'hCB), 1);
        do_load(32'hCB, -1, '0, 0);
        // R9: stalled store
        do_store(32'h45, 32'hCAFE_0001, 3);
        do_load(32'h45, -1, '0, 0);

        for (int n = 0; n < 600; n++) begin
            int r = $urandom % 10;
            logic [AW-1:0] a = $urandom % 256;
            if (r < 5) begin
                if ($urandom % 4 == 0)
                    do_load(a, $urandom % WORDS, ($urandom % 3 == 0) ? idx_of(a) : IDXW'($urandom), $urandom % 3);
                else
                    do_load(a, -1, '0, $urandom % 3);
            end else if (r < 8) begin
                do_store(a, $urandom, $urandom % 3);
            end else if (r == 8) begin
                do_inv(IDXW'($urandom));
            end else begin
                if ($urandom % 2 == 0) do_load(32'hF000_0000 | a, -1, '0, $urandom % 2);
                else do_store(32'hF000_0000 | a, $urandom, $urandom % 2);
            end
        end

        summary();
        $finish;
    end
endmodule